// File: doc/BRIEF.md
# Configuration Header Register File

This block is the device-side storage behind a Type-0 configuration header. A simple access port carries a dword index, write data, byte enables and a write flag. Reads come back one cycle later with a valid strobe. The block holds the identification constants, the Command and Status registers, six base address slots, a capabilities pointer and the interrupt routing bytes. It exports the decoded Command enables and a gated legacy interrupt request to the rest of the device.

Each base address slot is fixed at elaboration time by three parameters: its kind (absent, 32-bit memory, 64-bit memory or I/O), the log2 of its aperture and a prefetch flag. A 64-bit memory slot takes the next slot as its upper half. The address bits below the aperture are hardwired to zero. System software can therefore size a window by writing all ones and reading the slot back.

Error events from the bus logic set sticky Status flags. Software clears them by writing ones.

Top module: `cfg_hdr_regfile`

## Requirements
- R1: A read request (acc_req=1, acc_we=0) in cycle N gives rd_valid=1 in cycle N+1, with rd_data holding the dword at acc_dw as it was in cycle N. rd_valid is 0 in every other cycle, including after writes. acc_dw is a dword index, so index k is byte offset 4k.
- R2: These dwords are constants that ignore writes: index 0 is {DEVICE_ID, VENDOR_ID}, index 2 is {CLASS_CODE, REV_ID}, index 3 carries HDR_TYPE in bits 23:16, index 11 is {SUBSYS_ID, SUBSYS_VID}, and index 13 carries CAP_PTR in bits 7:0. Any index without a register reads zero.
- R3: Command is the low half of index 1. Only bits 0 (I/O decode), 1 (memory decode), 2 (bus master), 6 (parity response), 8 (system-error driver) and 10 (interrupt disable) are writable, and the other bits read 0. Each byte is written only when its byte enable is set. Outputs cmd_io_en, cmd_mem_en, cmd_bm_en, cmd_perr_en and cmd_serr_en follow bits 0, 1, 2, 6 and 8.
- R4: A 32-bit memory slot at indices 4 to 9 reads bit 0 = 0, bits 2:1 = 00 and bit 3 = its prefetch flag. Its address bits below max(4, log2 size) read zero, so an all-ones write reads back ~(size-1) with the flag added.
- R5: An I/O slot reads bit 0 = 1 and bit 1 = 0. Its address bits below max(2, log2 size) read zero.
- R6: The low slot of a 64-bit memory pair reads type bits 2:1 = 10. The following slot stores address bits 63:32, with bits below (log2 size − 32) hardwired to zero.
- R7: An absent slot reads zero and ignores writes.
- R8: Status bits 15:11 and 8 are cleared by writing 1 to them through bytes 2 and 3 of index 1. Writing 0 leaves them unchanged. An event in the same cycle as a clear leaves the bit set.
- R9: err_evt[0..4] set Status bits 11..15 respectively. mdpe_evt sets Status bit 8 only while Command bit 6 is 1.
- R10: Status bit 4 reads 1 when CAP_PTR is non-zero. Status bit 3 reads the live intx_pending input. All other Status bits that are not error flags read 0.
- R11: intx_assert equals intx_pending while Command bit 10 is 0, and is 0 while Command bit 10 is 1.
- R12: Index 15 reads {8'h00, 8'h00, INT_PIN, line}. The line byte (bits 7:0) is writable under byte enable 0.
- R13: After reset: every slot address bit is zero, Command is zero, the Status error flags are zero, the line byte is zero, and rd_valid and rd_data are zero.
- R14: A write to a base address slot changes only the bytes whose enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_dw | input | DW_W (6) | Dword index into the space |
| acc_be | input | 4 | Byte enables for writes |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| err_evt | input | 5 | Error event pulses for Status bits 11..15 |
| mdpe_evt | input | 1 | Master data parity error event |
| intx_pending | input | 1 | Device-internal interrupt condition |
| cmd_io_en | output | 1 | I/O decode enabled |
| cmd_mem_en | output | 1 | Memory decode enabled |
| cmd_bm_en | output | 1 | Bus mastering enabled |
| cmd_perr_en | output | 1 | Parity error response enabled |
| cmd_serr_en | output | 1 | System-error driver enabled |
| intx_assert | output | 1 | Interrupt request after the disable bit |

## Verification
The bench sizes every slot kind with all-ones writes. If the aperture mask or the read-only encoding is wrong, the readback values differ, and an absent slot that kept its data would read back non-zero. It drives an event and a one-to-clear write in the same cycle. It toggles the parity-response bit around a parity event, and a design that let either case through would show a flag dropping or appearing. Random sub-dword writes against a reference model catch any byte-enable leak across Command, Status and the slots. The model also catches any write landing on a constant dword.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int NUM_BARS = 6;
  localparam int BAR_DW0  = 4;

  typedef enum logic [2:0] {
    SLOT_NONE    = 3'd0,
    SLOT_MEM32   = 3'd1,
    SLOT_MEM64   = 3'd2,
    SLOT_IO      = 3'd3,
    SLOT_MEM64_HI = 3'd4
  } slot_kind_e;

  localparam int CMD_IO_BIT   = 0;
  localparam int CMD_MEM_BIT  = 1;
  localparam int CMD_BM_BIT   = 2;
  localparam int CMD_PERR_BIT = 6;
  localparam int CMD_SERR_BIT = 8;
  localparam int CMD_INTD_BIT = 10;

  localparam logic [15:0] CMD_WMASK    = 16'h0547;
  localparam logic [15:0] STS_W1C_MASK = 16'hF900;

  // all bits at position lo and above
  function automatic logic [31:0] ones_from(input int lo);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < 32; b++) begin
      if (b >= lo) m[b] = 1'b1;
    end
    return m;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] byte_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] m;
    m = be_mask(be);
    return (old_v & ~m) | (new_v & m);
  endfunction

  // writable address bits of one slot
  function automatic logic [31:0] bar_wmask(input slot_kind_e kind, input int log2sz);
    logic [31:0] m;
    case (kind)
      SLOT_MEM32:    m = ones_from(imax(4, log2sz));
      SLOT_MEM64:    m = (log2sz >= 32) ? 32'h0 : ones_from(imax(4, log2sz));
      SLOT_MEM64_HI: m = ones_from(imax(0, log2sz - 32));
      SLOT_IO:       m = ones_from(imax(2, log2sz));
      default:       m = 32'h0;
    endcase
    return m;
  endfunction

  // hardwired encoding bits of one slot
  function automatic logic [31:0] bar_ro_bits(input slot_kind_e kind, input bit pref);
    logic [31:0] r;
    case (kind)
      SLOT_MEM32: r = {28'h0, pref, 3'b000};
      SLOT_MEM64: r = {28'h0, pref, 3'b100};
      SLOT_IO:    r = 32'h1;
      default:    r = 32'h0;
    endcase
    return r;
  endfunction

  // role of a slot once 64-bit pairs have claimed their upper halves
  function automatic slot_kind_e slot_role(input logic [NUM_BARS*3-1:0] kinds, input int idx);
    slot_kind_e role;
    slot_kind_e cur;
    bit         hi_next;
    role    = SLOT_NONE;
    hi_next = 1'b0;
    for (int j = 0; j < NUM_BARS; j++) begin
      if (j <= idx) begin
        cur = slot_kind_e'(kinds[j*3 +: 3]);
        if (hi_next) begin
          role    = SLOT_MEM64_HI;
          hi_next = 1'b0;
        end else if (cur == SLOT_MEM64 && j == NUM_BARS - 1) begin
          role = SLOT_NONE;
        end else if (cur == SLOT_MEM64_HI || cur > SLOT_MEM64_HI) begin
          role = SLOT_NONE;
        end else begin
          role    = cur;
          hi_next = (cur == SLOT_MEM64);
        end
      end
    end
    return role;
  endfunction

  // aperture log2 that governs a slot (upper halves take their owner's)
  function automatic int slot_log2(input logic [NUM_BARS*3-1:0] kinds,
                                   input logic [NUM_BARS*6-1:0] log2s,
                                   input int idx);
    if (slot_role(kinds, idx) == SLOT_MEM64_HI && idx > 0)
      return int'(log2s[(idx-1)*6 +: 6]);
    return int'(log2s[idx*6 +: 6]);
  endfunction

endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
  import cfg_hdr_pkg::*;
#(
  parameter slot_kind_e KIND   = SLOT_NONE,
  parameter int         LOG2SZ = 12,
  parameter bit         PREF   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);

  localparam logic [31:0] WMASK = bar_wmask(KIND, LOG2SZ);
  localparam logic [31:0] RO    = bar_ro_bits(KIND, PREF);

  logic [31:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (wr_en) begin
      base_q <= byte_merge(base_q, wdata, be) & WMASK;
    end
  end

  assign rdata = (base_q & WMASK) | RO;

endmodule

// File: rtl/cfg_cmd_status.sv
module cfg_cmd_status
  import cfg_hdr_pkg::*;
#(
  parameter bit CAP_PRESENT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic [4:0]  err_evt,
  input  logic        mdpe_evt,
  input  logic        intx_pending,
  output logic [15:0] cmd_q,
  output logic [15:0] sts_err,
  output logic [15:0] status_rd,
  output logic [15:0] sts_set,
  output logic [15:0] sts_clr
);

  logic [15:0] cmd_r;
  logic [15:0] sts_r;
  logic [31:0] wmask;

  assign wmask = be_mask(be);

  // event and clear vectors, brought out for the checker
  assign sts_set = {err_evt, 2'b00, mdpe_evt & cmd_r[CMD_PERR_BIT], 8'h00};
  assign sts_clr = wr_en ? (wdata[31:16] & wmask[31:16] & STS_W1C_MASK) : 16'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_r <= '0;
      sts_r <= '0;
    end else begin
      if (wr_en) begin
        cmd_r <= ((cmd_r & ~wmask[15:0]) | (wdata[15:0] & wmask[15:0])) & CMD_WMASK;
      end
      sts_r <= (sts_r & ~sts_clr) | sts_set;
    end
  end

  assign cmd_q     = cmd_r;
  assign sts_err   = sts_r;
  assign status_rd = sts_r | {11'h0, CAP_PRESENT, intx_pending, 3'b000};

endmodule

// File: rtl/cfg_hdr_rdmux.sv
module cfg_hdr_rdmux
  import cfg_hdr_pkg::*;
#(
  parameter int          DW_W       = 6,
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
  parameter logic [7:0]  REV_ID     = 8'h02,
  parameter logic [23:0] CLASS_CODE = 24'h0C0330,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter logic [15:0] SUBSYS_VID = 16'h1A2B,
  parameter logic [15:0] SUBSYS_ID  = 16'h0001,
  parameter logic [7:0]  CAP_PTR    = 8'h40,
  parameter logic [7:0]  INT_PIN    = 8'h01
) (
  input  logic [DW_W-1:0]       dw,
  input  logic [15:0]           cmd,
  input  logic [15:0]           status,
  input  logic [NUM_BARS*32-1:0] bar_rd,
  input  logic [7:0]            int_line,
  output logic [31:0]           rdata
);

  always_comb begin
    rdata = 32'h0;
    case (dw)
      DW_W'(0):  rdata = {DEVICE_ID, VENDOR_ID};
      DW_W'(1):  rdata = {status, cmd};
      DW_W'(2):  rdata = {CLASS_CODE, REV_ID};
      DW_W'(3):  rdata = {8'h00, HDR_TYPE, 16'h0000};
      DW_W'(11): rdata = {SUBSYS_ID, SUBSYS_VID};
      DW_W'(13): rdata = {24'h0, CAP_PTR};
      DW_W'(15): rdata = {16'h0000, INT_PIN, int_line};
      default:   rdata = 32'h0;
    endcase
    for (int i = 0; i < NUM_BARS; i++) begin
      if (dw == DW_W'(BAR_DW0 + i)) rdata = bar_rd[i*32 +: 32];
    end
  end

endmodule

// File: rtl/cfg_hdr_regfile.sv
module cfg_hdr_regfile
  import cfg_hdr_pkg::*;
#(
  parameter int          DW_W       = 6,
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
  parameter logic [7:0]  REV_ID     = 8'h02,
  parameter logic [23:0] CLASS_CODE = 24'h0C0330,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter logic [15:0] SUBSYS_VID = 16'h1A2B,
  parameter logic [15:0] SUBSYS_ID  = 16'h0001,
  parameter logic [7:0]  CAP_PTR    = 8'h40,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  // per slot, slot 0 in the low bits: kind code, aperture log2, prefetch flag
  parameter logic [NUM_BARS*3-1:0] BAR_KINDS = {3'd1, 3'd0, 3'd0, 3'd2, 3'd3, 3'd1},
  parameter logic [NUM_BARS*6-1:0] BAR_LOG2  = {6'd8, 6'd0, 6'd0, 6'd20, 6'd5, 6'd12},
  parameter logic [NUM_BARS-1:0]   BAR_PREF  = 6'b000100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_req,
  input  logic            acc_we,
  input  logic [DW_W-1:0] acc_dw,
  input  logic [3:0]      acc_be,
  input  logic [31:0]     acc_wdata,
  output logic            rd_valid,
  output logic [31:0]     rd_data,
  input  logic [4:0]      err_evt,
  input  logic            mdpe_evt,
  input  logic            intx_pending,
  output logic            cmd_io_en,
  output logic            cmd_mem_en,
  output logic            cmd_bm_en,
  output logic            cmd_perr_en,
  output logic            cmd_serr_en,
  output logic            intx_assert
);

  localparam bit CAP_PRESENT = (CAP_PTR != 8'h00);
  localparam logic [DW_W-1:0] DW_CMD  = DW_W'(1);
  localparam logic [DW_W-1:0] DW_LINE = DW_W'(15);

  // named internal events
  logic                   wr_strobe;
  logic                   rd_strobe;
  logic                   cmd_wr;
  logic                   line_wr;
  logic [NUM_BARS-1:0]    bar_wr;
  logic [NUM_BARS*32-1:0] bar_rd;
  logic [15:0]            cmd_q;
  logic [15:0]            sts_err;
  logic [15:0]            status_rd;
  logic [15:0]            sts_set;
  logic [15:0]            sts_clr;
  logic [7:0]             int_line_q;
  logic [31:0]            rd_mux;

  assign wr_strobe = acc_req & acc_we;
  assign rd_strobe = acc_req & ~acc_we;
  assign cmd_wr    = wr_strobe && (acc_dw == DW_CMD);
  assign line_wr   = wr_strobe && (acc_dw == DW_LINE) && acc_be[0];

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    localparam slot_kind_e ROLE = slot_role(BAR_KINDS, i);
    localparam int         L2   = slot_log2(BAR_KINDS, BAR_LOG2, i);

    assign bar_wr[i] = wr_strobe && (acc_dw == DW_W'(BAR_DW0 + i));

    cfg_bar_slot #(
      .KIND   (ROLE),
      .LOG2SZ (L2),
      .PREF   (BAR_PREF[i])
    ) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (bar_wr[i]),
      .be    (acc_be),
      .wdata (acc_wdata),
      .rdata (bar_rd[i*32 +: 32])
    );
  end

  cfg_cmd_status #(
    .CAP_PRESENT (CAP_PRESENT)
  ) u_cmdsts (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cmd_wr),
    .be           (acc_be),
    .wdata        (acc_wdata),
    .err_evt      (err_evt),
    .mdpe_evt     (mdpe_evt),
    .intx_pending (intx_pending),
    .cmd_q        (cmd_q),
    .sts_err      (sts_err),
    .status_rd    (status_rd),
    .sts_set      (sts_set),
    .sts_clr      (sts_clr)
  );

  cfg_hdr_rdmux #(
    .DW_W       (DW_W),
    .VENDOR_ID  (VENDOR_ID),
    .DEVICE_ID  (DEVICE_ID),
    .REV_ID     (REV_ID),
    .CLASS_CODE (CLASS_CODE),
    .HDR_TYPE   (HDR_TYPE),
    .SUBSYS_VID (SUBSYS_VID),
    .SUBSYS_ID  (SUBSYS_ID),
    .CAP_PTR    (CAP_PTR),
    .INT_PIN    (INT_PIN)
  ) u_rdmux (
    .dw       (acc_dw),
    .cmd      (cmd_q),
    .status   (status_rd),
    .bar_rd   (bar_rd),
    .int_line (int_line_q),
    .rdata    (rd_mux)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_line_q <= '0;
    end else if (line_wr) begin
      int_line_q <= acc_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_strobe;
      if (rd_strobe) rd_data <= rd_mux;
    end
  end

  assign cmd_io_en   = cmd_q[CMD_IO_BIT];
  assign cmd_mem_en  = cmd_q[CMD_MEM_BIT];
  assign cmd_bm_en   = cmd_q[CMD_BM_BIT];
  assign cmd_perr_en = cmd_q[CMD_PERR_BIT];
  assign cmd_serr_en = cmd_q[CMD_SERR_BIT];
  assign intx_assert = intx_pending & ~cmd_q[CMD_INTD_BIT];

endmodule

// File: rtl/cfg_hdr_checker.sv
module cfg_hdr_checker
  import cfg_hdr_pkg::*;
#(
  parameter int DW_W = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                acc_req,
  input logic                acc_we,
  input logic [DW_W-1:0]     acc_dw,
  input logic                rd_valid,
  input logic [NUM_BARS-1:0] bar_wr,
  input logic [15:0]         cmd_q,
  input logic [15:0]         sts_err,
  input logic [15:0]         sts_set,
  input logic [15:0]         sts_clr,
  input logic                mdpe_evt
);

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_we) |=> rd_valid); // R1

  AST_NO_RD_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_req && !acc_we) |=> !rd_valid); // R1

  AST_BAR_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bar_wr)); // R14

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_req && acc_we && acc_dw == DW_W'(1)) |=> $stable(cmd_q)); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_err & $past(sts_err & ~sts_clr)) == $past(sts_err & ~sts_clr))); // R8

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_set != 16'h0) |=> ((sts_err & $past(sts_set)) == $past(sts_set))); // R9

  AST_MDPE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mdpe_evt && !cmd_q[CMD_PERR_BIT] && !sts_err[8]) |=> !sts_err[8]); // R9

endmodule

bind cfg_hdr_regfile cfg_hdr_checker #(.DW_W(DW_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_req  (acc_req),
  .acc_we   (acc_we),
  .acc_dw   (acc_dw),
  .rd_valid (rd_valid),
  .bar_wr   (bar_wr),
  .cmd_q    (cmd_q),
  .sts_err  (sts_err),
  .sts_set  (sts_set),
  .sts_clr  (sts_clr),
  .mdpe_evt (mdpe_evt)
);

// File: tb/cfg_hdr_regfile_bench.sv
`timescale 1ns/1ps
module cfg_hdr_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_req, acc_we;
  logic [5:0]  acc_dw;
  logic [3:0]  acc_be;
  logic [31:0] acc_wdata;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [4:0]  err_evt;
  logic        mdpe_evt, intx_pending;
  logic        cmd_io_en, cmd_mem_en, cmd_bm_en, cmd_perr_en, cmd_serr_en, intx_assert;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cfg_hdr_regfile u_cfg_hdr_regfile (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we), .acc_dw(acc_dw),
    .acc_be(acc_be), .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_evt(err_evt), .mdpe_evt(mdpe_evt), .intx_pending(intx_pending),
    .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en), .cmd_bm_en(cmd_bm_en),
    .cmd_perr_en(cmd_perr_en), .cmd_serr_en(cmd_serr_en), .intx_assert(intx_assert)
  );

  // reference state
  logic [31:0] bar_m [6];
  logic [15:0] cmd_m, sts_m;
  logic [7:0]  line_m;

  function automatic logic [31:0] bm_wmask(input int k);
    case (k)
      0: return 32'hFFFF_F000;   // 4 KiB memory
      1: return 32'hFFFF_FFE0;   // 32 B I/O
      2: return 32'hFFF0_0000;   // 1 MiB 64-bit low
      3: return 32'hFFFF_FFFF;   // 64-bit high
      5: return 32'hFFFF_FF00;   // 256 B memory
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] bm_ro(input int k);
    case (k)
      1: return 32'h1;
      2: return 32'hC;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [5:0] dw, input logic pend);
    case (dw)
      6'd0:  return 32'h3C4D_1A2B;
      6'd1:  return {sts_m | 16'h0010 | (pend ? 16'h0008 : 16'h0), cmd_m};
      6'd2:  return 32'h0C03_3002;
      6'd11: return 32'h0001_1A2B;
      6'd13: return 32'h0000_0040;
      6'd15: return {16'h0, 8'h01, line_m};
      6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9: return bar_m[int'(dw) - 4] | bm_ro(int'(dw) - 4);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] dw);
    case (dw)
      6'd1:  return "R3";
      6'd4, 6'd9: return "R4";
      6'd5:  return "R5";
      6'd6, 6'd7: return "R6";
      6'd8:  return "R7";
      6'd15: return "R12";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_update(input logic req, input logic we, input logic [5:0] dw,
                              input logic [3:0] be, input logic [31:0] wd,
                              input logic [4:0] ev, input logic mdpe);
    logic [15:0] setv, clrv;
    setv = {ev, 2'b00, mdpe & cmd_m[6], 8'h00};
    clrv = 16'h0;
    if (req && we) begin
      if (dw == 6'd1) begin
        for (int b = 0; b < 2; b++) if (be[b]) cmd_m[8*b +: 8] = wd[8*b +: 8];
        cmd_m = cmd_m & 16'h0547;
        clrv = wd[31:16] & {{8{be[3]}}, {8{be[2]}}} & 16'hF900;
      end else if (dw >= 6'd4 && dw <= 6'd9) begin
        for (int b = 0; b < 4; b++) if (be[b]) bar_m[int'(dw) - 4][8*b +: 8] = wd[8*b +: 8];
        bar_m[int'(dw) - 4] = bar_m[int'(dw) - 4] & bm_wmask(int'(dw) - 4);
      end else if (dw == 6'd15 && be[0]) begin
        line_m = wd[7:0];
      end
    end
    sts_m = (sts_m & ~clrv) | setv;
  endtask

  // one cycle: drive at the falling edge, sample at the next falling edge
  task automatic cyc(input string tag, input logic req, input logic we, input logic [5:0] dw,
                     input logic [3:0] be, input logic [31:0] wd, input logic [4:0] ev,
                     input logic mdpe, input logic pend);
    logic [31:0] exp;
    acc_req = req; acc_we = we; acc_dw = dw; acc_be = be; acc_wdata = wd;
    err_evt = ev; mdpe_evt = mdpe; intx_pending = pend;
    exp = exp_read(dw, pend);
    @(posedge clk);
    model_update(req, we, dw, be, wd, ev, mdpe);
    @(negedge clk);
    if (req && !we) begin
      chk("R1", {31'h0, rd_valid}, 32'h1);
      chk(tag, rd_data, exp);
    end else begin
      chk("R1", {31'h0, rd_valid}, 32'h0);
    end
    chk("R3", {27'h0, cmd_io_en, cmd_mem_en, cmd_bm_en, cmd_perr_en, cmd_serr_en},
        {27'h0, cmd_m[0], cmd_m[1], cmd_m[2], cmd_m[6], cmd_m[8]});
    chk("R11", {31'h0, intx_assert}, {31'h0, pend & ~cmd_m[10]});
  endtask

  task automatic wr(input string tag, input logic [5:0] dw, input logic [3:0] be, input logic [31:0] wd);
    cyc(tag, 1'b1, 1'b1, dw, be, wd, 5'h0, 1'b0, 1'b0);
  endtask

  task automatic rd(input string tag, input logic [5:0] dw, input logic pend);
    cyc(tag, 1'b1, 1'b0, dw, 4'h0, 32'h0, 5'h0, 1'b0, pend);
  endtask

  task automatic idle_ev(input logic [4:0] ev, input logic mdpe);
    cyc("R9", 1'b0, 1'b0, 6'd0, 4'h0, 32'h0, ev, mdpe, 1'b0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    for (int k = 0; k < 6; k++) bar_m[k] = 32'h0;
    cmd_m = 16'h0; sts_m = 16'h0; line_m = 8'h0;
    acc_req = 1'b0; acc_we = 1'b0; acc_dw = '0; acc_be = '0; acc_wdata = '0;
    err_evt = '0; mdpe_evt = 1'b0; intx_pending = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R13", {31'h0, rd_valid}, 32'h0);
    chk("R13", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 / R2: whole space after reset
    for (int d = 0; d < 64; d++) rd(((d >= 4 && d <= 9) || d == 1) ? "R13" : tag_of(6'(d)), 6'(d), 1'b0);

    // R2: constants ignore writes
    wr("R2", 6'd0, 4'hF, 32'hFFFF_FFFF);
    rd("R2", 6'd0, 1'b0);
    wr("R2", 6'd13, 4'hF, 32'hFFFF_FFFF);
    rd("R2", 6'd13, 1'b0);
    wr("R2", 6'd20, 4'hF, 32'hFFFF_FFFF);
    rd("R2", 6'd20, 1'b0);

    // sizing: all ones into every slot
    for (int d = 4; d <= 9; d++) wr("R4", 6'(d), 4'hF, 32'hFFFF_FFFF);
    rd("R4", 6'd4, 1'b0); chk("R4", rd_data, 32'hFFFF_F000);
    rd("R5", 6'd5, 1'b0); chk("R5", rd_data, 32'hFFFF_FFE1);
    rd("R6", 6'd6, 1'b0); chk("R6", rd_data, 32'hFFF0_000C);
    rd("R6", 6'd7, 1'b0); chk("R6", rd_data, 32'hFFFF_FFFF);
    rd("R7", 6'd8, 1'b0); chk("R7", rd_data, 32'h0);
    rd("R4", 6'd9, 1'b0); chk("R4", rd_data, 32'hFFFF_FF00);

    // R14: byte enables on a slot
    wr("R14", 6'd4, 4'hF, 32'h0);
    wr("R14", 6'd4, 4'b0100, 32'h12AB_CDEF);
    rd("R14", 6'd4, 1'b0); chk("R14", rd_data, 32'h00AB_0000);

    // R3: partial command writes
    wr("R3", 6'd1, 4'b0001, 32'hFFFF_FFFF);
    rd("R3", 6'd1, 1'b0); chk("R3", rd_data[15:0], 16'h0047);
    wr("R3", 6'd1, 4'b0010, 32'hFFFF_FFFF);
    rd("R3", 6'd1, 1'b0); chk("R3", rd_data[15:0], 16'h0547);

    // R11 / R10: interrupt gating and live status bit
    rd("R10", 6'd1, 1'b1); chk("R10", rd_data[31:16], 16'h0018);
    wr("R11", 6'd1, 4'b0011, 32'h0000_0003);
    rd("R11", 6'd1, 1'b1);
    rd("R10", 6'd1, 1'b0); chk("R10", rd_data[31:16], 16'h0010);

    // R9: events set sticky flags; parity flag gated by command bit 6 (now 0)
    idle_ev(5'b10101, 1'b1);
    rd("R9", 6'd1, 1'b0); chk("R9", rd_data[31:16], 16'hA810);
    wr("R3", 6'd1, 4'b0001, 32'h0000_0040);
    idle_ev(5'b00000, 1'b1);
    rd("R9", 6'd1, 1'b0); chk("R9", rd_data[31:16], 16'hA910);

    // R8: zero writes keep, one writes clear, set beats clear
    wr("R8", 6'd1, 4'b1100, 32'h0000_0040);
    rd("R8", 6'd1, 1'b0); chk("R8", rd_data[31:16], 16'hA910);
    wr("R8", 6'd1, 4'b1000, 32'h8000_0040);
    rd("R8", 6'd1, 1'b0); chk("R8", rd_data[31:16], 16'h2910);
    cyc("R8", 1'b1, 1'b1, 6'd1, 4'b1100, 32'hFFFF_0040, 5'b00001, 1'b0, 1'b0);
    rd("R8", 6'd1, 1'b0); chk("R8", rd_data[31:16], 16'h0810);

    // R12: interrupt line byte
    wr("R12", 6'd15, 4'b1110, 32'hFFFF_FF5A);
    rd("R12", 6'd15, 1'b0); chk("R12", rd_data, 32'h0000_0100);
    wr("R12", 6'd15, 4'b0001, 32'hFFFF_FF5A);
    rd("R12", 6'd15, 1'b0); chk("R12", rd_data, 32'h0000_015A);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [5:0]  dw;
      logic        we;
      logic [4:0]  ev;
      dw = ($urandom % 8 == 0) ? 6'($urandom) : 6'($urandom % 16);
      we = ($urandom % 2 == 0);
      ev = ($urandom % 6 == 0) ? 5'($urandom) : 5'h0;
      cyc(tag_of(dw), ($urandom % 5 != 0), we, dw, 4'($urandom),
          ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom,
          ev, ($urandom % 6 == 0), 1'($urandom));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule